// File: doc/BRIEF.md
# Receive Buffer Ring Engine

This block is the hardware half of a receive descriptor ring. Software hands the engine empty buffers: for each one it writes a descriptor slot with the buffer's base address, which also clears the slot's length and flag fields. It then moves a write-index register past the posted slots. While the engine's read index trails the write index, the engine owns the slot at its read index. It loads that slot's buffer address, accepts a word stream from the sending side and stores each word into consecutive buffer locations. When the final word arrives, it records the byte count and the transfer's flags in the slot. Only in the next cycle does it step its read index.

Software detects a finished slot in either of two ways: the length field is non-zero, or the read index has moved past the slot. Because the length is written first, software never sees a moved index over a slot whose length is still zero. When no buffer is posted, the engine holds off the stream. A transfer longer than the buffer is cut at the buffer size, and the slot and a sticky status bit both record the overflow. A gathered transfer is one that software assembled from several pieces. It reaches the engine as a single stream with one end marker, so it fills one buffer and consumes one slot.

Top module: `rx_buf_ring`

## Requirements
- R1: After reset the read index is 0, `in_ready` and `mem_we` are low and `ovf_status` is low; every slot reads back address 0, length 0 and flags 0.
- R2: While the read index equals the write index (ring empty), `in_ready` stays low and no memory write is issued.
- R3: Posting a slot stores the given address and clears that slot's length and flags to zero, even if the slot held a completed transfer.
- R4: The k-th accepted word of a transfer (k from 0) is written with `mem_wdata` equal to the input word at address base + k*(DATA_W/8), in the same cycle it is accepted; cycles without `in_valid` write nothing.
- R5: One clock edge after the final word (`in_last`) is accepted, the slot's length field holds the number of stored words times DATA_W/8; at that point the read index has not yet moved.
- R6: The read index advances by exactly one, on the clock edge after the length writeback; it never moves otherwise.
- R7: The flags field is written with `in_meta` in bits [META_W-1:0], `in_swap` in bit META_W and the overflow marker in bit META_W+1, sampled on the final word.
- R8: The read index wraps from DEPTH-1 to 0 (masked arithmetic, DEPTH a power of two).
- R9: Words beyond MAX_BEATS are accepted but not written; the length saturates at MAX_BEATS*(DATA_W/8), flag bit META_W+1 is set, and `ovf_status` goes high and stays high until `ovf_clr` is pulsed, after which it reads low one edge later.
- R10: A multi-word transfer with `in_last` only on its final word lands contiguously in one buffer and consumes exactly one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_post_we | input | 1 | Post a buffer into a slot |
| sw_post_idx | input | IDX_W | Slot being posted |
| sw_post_addr | input | ADDR_W | Buffer base address |
| sw_widx_we | input | 1 | Load the write index |
| sw_widx_val | input | IDX_W | New write index |
| sw_rd_idx | input | IDX_W | Slot to read back |
| sw_rd_addr | output | ADDR_W | Address of the read-back slot |
| sw_rd_len | output | LEN_W | Byte count of the read-back slot (0 = not done) |
| sw_rd_flags | output | META_W+2 | Flags of the read-back slot |
| hw_ridx | output | IDX_W | Engine read index |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Engine accepts a word |
| in_data | input | DATA_W | Stream word |
| in_last | input | 1 | Final word of the transfer |
| in_meta | input | META_W | Transfer metadata id |
| in_swap | input | 1 | Byte-swap marker of the transfer |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_addr | output | ADDR_W | Buffer memory byte address |
| mem_wdata | output | DATA_W | Buffer memory write data |
| ovf_clr | input | 1 | Clear the sticky overflow status |
| ovf_status | output | 1 | Sticky truncation indicator |

## Verification
Memory writes come straight from the accept handshake, so each word is checked between edges in the cycle it is offered with `in_ready` high. The slot's length is checked at three points. Half a cycle after the final-word edge it must still be zero. One edge later it must hold the byte count while the read index still shows the old slot. The index step is checked one further edge on. Overflow clearing is sampled one edge after the `ovf_clr` pulse. The empty-ring stall is observed over several cycles of offered data with no slot posted.

// File: rtl/rxr_pkg.sv
// Shared types for the receive buffer ring engine.
package rxr_pkg;

    // Transfer sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_DATA  = 3'd2,
        ST_WBACK = 3'd3,
        ST_ADV   = 3'd4
    } rxr_state_e;

endpackage

// File: rtl/rxr_desc_store.sv
// Descriptor slot storage.
// Holds address, length and flags for each ring slot. Software posts a slot
// (address written, length and flags cleared); the engine writes back the
// length and flags. An engine writeback to the same slot in the same cycle
// as a post takes precedence. Assumes software never posts a slot the
// engine currently owns.
module rxr_desc_store #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int FLG_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_we,
    input  logic [IDX_W-1:0]  post_idx,
    input  logic [ADDR_W-1:0] post_addr,
    input  logic              wb_we,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [LEN_W-1:0]  wb_len,
    input  logic [FLG_W-1:0]  wb_flags,
    input  logic              adv,
    input  logic [IDX_W-1:0]  eng_idx,
    output logic [ADDR_W-1:0] eng_addr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LEN_W-1:0]  rd_len,
    output logic [FLG_W-1:0]  rd_flags
);

    logic [DEPTH-1:0][ADDR_W-1:0] addr_all;
    logic [DEPTH-1:0][LEN_W-1:0]  len_all;
    logic [DEPTH-1:0][FLG_W-1:0]  flg_all;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [ADDR_W-1:0] addr_q;
        logic [LEN_W-1:0]  len_q;
        logic [FLG_W-1:0]  flg_q;
        logic              wb_hit;
        logic              post_hit;

        assign wb_hit   = wb_we   && (wb_idx   == IDX_W'(i));
        assign post_hit = post_we && (post_idx == IDX_W'(i));

        // Slot update: engine writeback first, else software post.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q <= '0;
                len_q  <= '0;
                flg_q  <= '0;
            end else if (wb_hit) begin
                len_q  <= wb_len;
                flg_q  <= wb_flags;
            end else if (post_hit) begin
                addr_q <= post_addr;
                len_q  <= '0;
                flg_q  <= '0;
            end
        end

        assign addr_all[i] = addr_q;
        assign len_all[i]  = len_q;
        assign flg_all[i]  = flg_q;
    end

    assign eng_addr = addr_all[eng_idx];
    assign rd_addr  = addr_all[rd_idx];
    assign rd_len   = len_all[rd_idx];
    assign rd_flags = flg_all[rd_idx];

    // R5: the slot being released must already carry a non-zero length.
    a_r5_len_before_adv: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (len_all[eng_idx] != '0))
        else $error("a_r5_len_before_adv");

endmodule

// File: rtl/rxr_ring_ctrl.sv
// Ring index control.
// Keeps the software-loaded write index and the engine read index. The read
// index steps by one on each advance and wraps by width truncation, which
// assumes DEPTH is a power of two. Empty means both indices match.
module rxr_ring_ctrl #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             widx_we,
    input  logic [IDX_W-1:0] widx_val,
    input  logic             adv,
    output logic [IDX_W-1:0] ridx,
    output logic             ring_empty
);

    logic [IDX_W-1:0] ridx_q;
    logic [IDX_W-1:0] widx_q;

    // Write index: loaded by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       widx_q <= '0;
        else if (widx_we) widx_q <= widx_val;
    end

    // Read index: one masked step per released slot.
    always_ff @(posedge clk) begin
        if (!rst_n)   ridx_q <= '0;
        else if (adv) ridx_q <= ridx_q + 1'b1;
    end

    assign ridx       = ridx_q;
    assign ring_empty = (ridx_q == widx_q);

    // R6/R8: any movement of the read index is a single wrapped step.
    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ridx_q != $past(ridx_q)) |-> (ridx_q == IDX_W'($past(ridx_q) + 1'b1)))
        else $error("a_r6_single_step");

endmodule

// File: rtl/rxr_xfer_fsm.sv
// Transfer sequencer.
// Loads the buffer address of the owned slot, writes stream words into the
// buffer, truncates past MAX_BEATS, writes back length and flags, then
// requests a read-index step in the following cycle. Assumes the ring is
// non-empty whenever it leaves the idle state and that software does not
// move the write index back over an owned slot.
module rxr_xfer_fsm
    import rxr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int META_W    = 5,
    parameter int LEN_W     = 16,
    parameter int MAX_BEATS = 16,
    localparam int FLG_W    = META_W + 2,
    localparam int BYTES    = DATA_W / 8,
    localparam int BEAT_W   = $clog2(MAX_BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_empty,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic [META_W-1:0] in_meta,
    input  logic              in_swap,
    output logic              in_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wb_we,
    output logic [LEN_W-1:0]  wb_len,
    output logic [FLG_W-1:0]  wb_flags,
    output logic              adv,
    input  logic              ovf_clr,
    output logic              ovf_status
);

    rxr_state_e        state_q;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] cnt_q;
    logic              ovf_q;
    logic [META_W-1:0] meta_q;
    logic              swap_q;
    logic              ovf_sticky_q;
    logic              accept;
    logic              room;
    logic              drop;

    assign in_ready = (state_q == ST_DATA);
    assign accept   = in_valid && in_ready;
    assign room     = (cnt_q < BEAT_W'(MAX_BEATS));
    assign drop     = accept && !room;

    assign mem_we    = accept && room;
    assign mem_addr  = base_q + ADDR_W'(32'(cnt_q) * BYTES);
    assign mem_wdata = in_data;

    assign wb_we    = (state_q == ST_WBACK);
    assign wb_len   = LEN_W'(32'(cnt_q) * BYTES);
    assign wb_flags = {ovf_q, swap_q, meta_q};
    assign adv      = (state_q == ST_ADV);

    assign ovf_status = ovf_sticky_q;

    // State sequence: idle -> load -> data -> writeback -> advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (!ring_empty) state_q <= ST_LOAD;
                ST_LOAD:  state_q <= ST_DATA;
                ST_DATA:  if (accept && in_last) state_q <= ST_WBACK;
                ST_WBACK: state_q <= ST_ADV;
                ST_ADV:   state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Per-transfer context: buffer base, word count, overflow and tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
            meta_q <= '0;
            swap_q <= 1'b0;
        end else if (state_q == ST_LOAD) begin
            base_q <= desc_addr;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
        end else if (accept) begin
            if (room) cnt_q <= cnt_q + 1'b1;
            if (drop) ovf_q <= 1'b1;
            if (in_last) begin
                meta_q <= in_meta;
                swap_q <= in_swap;
            end
        end
    end

    // Sticky overflow status: a new drop wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_sticky_q <= 1'b0;
        else if (drop)    ovf_sticky_q <= 1'b1;
        else if (ovf_clr) ovf_sticky_q <= 1'b0;
    end

    // R9: the stored word count never exceeds the buffer size.
    a_r9_beats_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= BEAT_W'(MAX_BEATS))
        else $error("a_r9_beats_bounded");

    // R4: back-to-back buffer writes land on consecutive word addresses.
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
            (mem_addr == $past(mem_addr) + ADDR_W'(BYTES)))
        else $error("a_r4_addr_step");

    // R5: writeback is always followed by exactly the index advance.
    a_r5_wb_then_adv: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |=> adv)
        else $error("a_r5_wb_then_adv");

endmodule

// File: rtl/rx_buf_ring.sv
// Receive buffer ring engine, top level.
// Joins the descriptor store, the index control and the transfer sequencer.
// Assumes DEPTH is a power of two and that software keeps one slot free so
// a full ring is never mistaken for an empty one.
module rx_buf_ring #(
    parameter int DEPTH     = 8,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int META_W    = 5,
    parameter int LEN_W     = 16,
    parameter int MAX_BEATS = 16,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int FLG_W    = META_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_post_we,
    input  logic [IDX_W-1:0]  sw_post_idx,
    input  logic [ADDR_W-1:0] sw_post_addr,
    input  logic              sw_widx_we,
    input  logic [IDX_W-1:0]  sw_widx_val,
    input  logic [IDX_W-1:0]  sw_rd_idx,
    output logic [ADDR_W-1:0] sw_rd_addr,
    output logic [LEN_W-1:0]  sw_rd_len,
    output logic [FLG_W-1:0]  sw_rd_flags,
    output logic [IDX_W-1:0]  hw_ridx,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic [META_W-1:0] in_meta,
    input  logic              in_swap,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              ovf_clr,
    output logic              ovf_status
);

    logic              ring_empty;
    logic              adv;
    logic              wb_we;
    logic [LEN_W-1:0]  wb_len;
    logic [FLG_W-1:0]  wb_flags;
    logic [ADDR_W-1:0] eng_addr;
    logic [IDX_W-1:0]  ridx;

    assign hw_ridx = ridx;

    rxr_ring_ctrl #(
        .IDX_W (IDX_W)
    ) ring_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .widx_we    (sw_widx_we),
        .widx_val   (sw_widx_val),
        .adv        (adv),
        .ridx       (ridx),
        .ring_empty (ring_empty)
    );

    rxr_desc_store #(
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .FLG_W  (FLG_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .post_we   (sw_post_we),
        .post_idx  (sw_post_idx),
        .post_addr (sw_post_addr),
        .wb_we     (wb_we),
        .wb_idx    (ridx),
        .wb_len    (wb_len),
        .wb_flags  (wb_flags),
        .adv       (adv),
        .eng_idx   (ridx),
        .eng_addr  (eng_addr),
        .rd_idx    (sw_rd_idx),
        .rd_addr   (sw_rd_addr),
        .rd_len    (sw_rd_len),
        .rd_flags  (sw_rd_flags)
    );

    rxr_xfer_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .META_W    (META_W),
        .LEN_W     (LEN_W),
        .MAX_BEATS (MAX_BEATS)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_empty (ring_empty),
        .desc_addr  (eng_addr),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_meta    (in_meta),
        .in_swap    (in_swap),
        .in_ready   (in_ready),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .wb_we      (wb_we),
        .wb_len     (wb_len),
        .wb_flags   (wb_flags),
        .adv        (adv),
        .ovf_clr    (ovf_clr),
        .ovf_status (ovf_status)
    );

    // R2: an empty ring never offers ready to the stream.
    a_r2_empty_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        ring_empty |-> !in_ready)
        else $error("a_r2_empty_stalls");

    // R2: no buffer write follows a cycle in which the ring was empty.
    a_r2_empty_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ring_empty |=> !mem_we)
        else $error("a_r2_empty_no_write");

endmodule

// File: tb/rx_buf_ring_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the receive buffer ring engine.
module rx_buf_ring_tb_top;

    localparam int DEPTH     = 8;
    localparam int IDX_W     = 3;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int META_W    = 5;
    localparam int LEN_W     = 16;
    localparam int MAX_BEATS = 16;
    localparam int FLG_W     = META_W + 2;
    localparam int BYTES     = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sw_post_we = 1'b0;
    logic [IDX_W-1:0]  sw_post_idx = '0;
    logic [ADDR_W-1:0] sw_post_addr = '0;
    logic              sw_widx_we = 1'b0;
    logic [IDX_W-1:0]  sw_widx_val = '0;
    logic [IDX_W-1:0]  sw_rd_idx = '0;
    logic [ADDR_W-1:0] sw_rd_addr;
    logic [LEN_W-1:0]  sw_rd_len;
    logic [FLG_W-1:0]  sw_rd_flags;
    logic [IDX_W-1:0]  hw_ridx;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_last = 1'b0;
    logic [META_W-1:0] in_meta = '0;
    logic              in_swap = 1'b0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              ovf_clr = 1'b0;
    logic              ovf_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [IDX_W-1:0] exp_ridx = '0;

    always #2 clk = ~clk;

    rx_buf_ring dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_post_we   (sw_post_we),
        .sw_post_idx  (sw_post_idx),
        .sw_post_addr (sw_post_addr),
        .sw_widx_we   (sw_widx_we),
        .sw_widx_val  (sw_widx_val),
        .sw_rd_idx    (sw_rd_idx),
        .sw_rd_addr   (sw_rd_addr),
        .sw_rd_len    (sw_rd_len),
        .sw_rd_flags  (sw_rd_flags),
        .hw_ridx      (hw_ridx),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .in_last      (in_last),
        .in_meta      (in_meta),
        .in_swap      (in_swap),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .ovf_clr      (ovf_clr),
        .ovf_status   (ovf_status)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic post_slot(input logic [IDX_W-1:0] idx, input logic [ADDR_W-1:0] a);
        sw_post_we = 1'b1; sw_post_idx = idx; sw_post_addr = a;
        @(negedge clk);
        sw_post_we = 1'b0;
    endtask

    task automatic set_widx(input logic [IDX_W-1:0] v);
        sw_widx_we = 1'b1; sw_widx_val = v;
        @(negedge clk);
        sw_widx_we = 1'b0;
    endtask

    // R1: state straight after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(hw_ridx == 0, "R1 ridx", 64'(hw_ridx), 0);
        chk(!in_ready, "R1 in_ready", 64'(in_ready), 0);
        chk(!mem_we, "R1 mem_we", 64'(mem_we), 0);
        chk(!ovf_status, "R1 ovf_status", 64'(ovf_status), 0);
        sw_rd_idx = 3'd5;
        #1;
        chk(sw_rd_len == 0 && sw_rd_flags == 0 && sw_rd_addr == 0, "R1 slot clear",
            64'(sw_rd_len), 0);
        @(negedge clk);
    endtask

    // R2: stream offered with nothing posted is held off.
    task automatic t_empty_stall();
        in_valid = 1'b1; in_data = 32'hDEAD_BEEF; in_last = 1'b1;
        for (int c = 0; c < 5; c++) begin
            #1;
            chk(!in_ready, "R2 ready while empty", 64'(in_ready), 0);
            chk(!mem_we, "R2 write while empty", 64'(mem_we), 0);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        #1;
        chk(hw_ridx == 0, "R2 ridx unchanged", 64'(hw_ridx), 0);
        @(negedge clk);
    endtask

    // R3..R7, R10: one transfer of nb words into the slot at the read index.
    task automatic do_xfer(input int nb, input logic [META_W-1:0] meta,
                           input logic sw, input bit gap);
        logic [IDX_W-1:0]  slot;
        logic [ADDR_W-1:0] base;
        int                kept;
        logic [FLG_W-1:0]  exp_flags;
        slot = exp_ridx;
        base = 32'h4000_0000 + 32'(slot) * 32'h1000 + 32'(nb) * 32'h10;
        post_slot(slot, base);
        sw_rd_idx = slot;
        #1;
        chk(sw_rd_addr == base, "R3 posted addr", 64'(sw_rd_addr), 64'(base));
        chk(sw_rd_len == 0 && sw_rd_flags == 0, "R3 posted len/flags cleared",
            64'(sw_rd_len), 0);
        @(negedge clk);
        set_widx(slot + 1'b1);
        for (int k = 0; k < nb; k++) begin
            if (gap && k == 2) begin
                in_valid = 1'b0;
                while (!in_ready) @(negedge clk);
                #1;
                chk(!mem_we, "R4 no write without valid", 64'(mem_we), 0);
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = 32'hA500_0000 + (32'(meta) << 16) + 32'(k);
            in_last  = (k == nb - 1);
            in_meta  = meta;
            in_swap  = sw;
            while (!in_ready) @(negedge clk);
            #1;
            if (k < MAX_BEATS) begin
                chk(mem_we, "R4 write strobe", 64'(mem_we), 1);
                chk(mem_addr == base + 32'(k * BYTES), "R4/R10 write address",
                    64'(mem_addr), 64'(base + 32'(k * BYTES)));
                chk(mem_wdata == in_data, "R4 write data", 64'(mem_wdata), 64'(in_data));
            end else begin
                chk(!mem_we, "R9 dropped word not written", 64'(mem_we), 0);
            end
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        kept = (nb > MAX_BEATS) ? MAX_BEATS : nb;
        exp_flags = {(nb > MAX_BEATS), sw, meta};
        #1;
        chk(sw_rd_len == 0, "R5 length still zero before writeback", 64'(sw_rd_len), 0);
        @(negedge clk);
        #1;
        chk(sw_rd_len == LEN_W'(kept * BYTES), "R5 written length",
            64'(sw_rd_len), 64'(kept * BYTES));
        chk(hw_ridx == slot, "R5 index held during writeback", 64'(hw_ridx), 64'(slot));
        @(negedge clk);
        #1;
        exp_ridx = slot + 1'b1;
        chk(hw_ridx == exp_ridx, "R6/R10 index single step", 64'(hw_ridx), 64'(exp_ridx));
        chk(sw_rd_flags == exp_flags, "R7 flags field", 64'(sw_rd_flags), 64'(exp_flags));
        @(negedge clk);
        #1;
        chk(hw_ridx == exp_ridx, "R6 index stable after step", 64'(hw_ridx), 64'(exp_ridx));
        @(negedge clk);
    endtask

    // R3: reposting a completed slot clears its length and flags.
    task automatic t_repost_clears(input logic [IDX_W-1:0] slot);
        sw_rd_idx = slot;
        #1;
        chk(sw_rd_len != 0, "R3 completed slot before repost", 64'(sw_rd_len), 1);
        @(negedge clk);
        post_slot(slot, 32'h7777_0000);
        #1;
        chk(sw_rd_len == 0 && sw_rd_flags == 0, "R3 repost clears", 64'(sw_rd_len), 0);
        chk(sw_rd_addr == 32'h7777_0000, "R3 repost addr", 64'(sw_rd_addr), 64'h7777_0000);
        @(negedge clk);
    endtask

    // R9: truncation and the sticky overflow status.
    task automatic t_truncate();
        #1;
        chk(!ovf_status, "R9 status low before overflow", 64'(ovf_status), 0);
        @(negedge clk);
        do_xfer(MAX_BEATS + 4, 5'h0A, 1'b0, 1'b0);
        chk(ovf_status, "R9 status set", 64'(ovf_status), 1);
        repeat (2) @(negedge clk);
        #1;
        chk(ovf_status, "R9 status sticky", 64'(ovf_status), 1);
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        #1;
        chk(!ovf_status, "R9 status cleared", 64'(ovf_status), 0);
        @(negedge clk);
        // The next transfer must not inherit the overflow marker (R7/R9).
        do_xfer(MAX_BEATS, 5'h01, 1'b0, 1'b0);
        chk(!ovf_status, "R9 exact fit does not overflow", 64'(ovf_status), 0);
    endtask

    // R8: read index wraps after the last slot.
    task automatic t_wrap();
        while (exp_ridx != IDX_W'(DEPTH - 1)) do_xfer(2, 5'h03, 1'b1, 1'b0);
        do_xfer(1, 5'h04, 1'b0, 1'b0);
        chk(hw_ridx == 0, "R8 wrap to zero", 64'(hw_ridx), 0);
        do_xfer(3, 5'h05, 1'b0, 1'b0);
        chk(hw_ridx == 1, "R8 continue after wrap", 64'(hw_ridx), 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_empty_stall();
        do_xfer(1, 5'h03, 1'b0, 1'b0);
        do_xfer(5, 5'h1F, 1'b1, 1'b1);
        t_repost_clears(3'd0);
        t_truncate();
        t_wrap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule